// File: doc/BRIEF.md
# Amplifier Protection and Power-State Supervisor

This block decides, every clock cycle, whether the output stage of a two-channel switching amplifier may drive its load, or must sit in a weak pull-down state. It reacts to a sleep request, a mute request, a supply-good comparator flag (the hysteresis lives in the comparator), per-channel overcurrent flags, an 8-bit die temperature code in degrees Celsius, and per-channel flags saying that the output holds a DC level above its threshold.

Four kinds of event are told apart. Overcurrent and persistent DC are latched: they clear only through sleep or loss of supply. A thermal event has two stages. The first stage only asks for a reduced power limit. The second stage shuts the output down. Both stages release below a common lower temperature. Undervoltage and mute hold the outputs off but do not flag an error. Leaving sleep, undervoltage or any fault costs a programmable wake delay. Leaving mute costs a shorter programmable recovery delay. The error output models an open-drain pin. If it is wired back to the sleep input, a fault clears itself and the block retries.

Top module: `amp_guard`

## Requirements
- R1: While sleep_ni is low, the next clock edge gives drive_en_o=0, weak_low_o=1 and err_low_o=0, and clears every latched fault and both thermal stages (plim_cut_o=0).
- R2: If supply_ok_i=1 and mute_ni=1 and sleep_ni is first sampled high at edge k, drive_en_o becomes 1 at edge k+WAKE_CYC and not before.
- R3: While mute_ni is low, drive_en_o=0 from the next edge on and err_low_o is not raised. If no wake delay is pending, drive_en_o returns MUTE_CYC edges after the edge that first samples mute_ni high.
- R4: Any bit of ocp_i set, with sleep_ni=1 and supply_ok_i=1, gives err_low_o=1 and drive_en_o=0 at the next edge.
- R5: A latched fault holds err_low_o=1 after its cause goes away and while mute_ni toggles. Only sleep_ni low or supply_ok_i low clears it.
- R6: A temperature code of at least TEMP_LIM (default 155) sets plim_cut_o at the next edge, with err_low_o=0 and drive unchanged. plim_cut_o stays set for codes between TEMP_REL and TEMP_LIM. It clears at the first edge that samples a code below TEMP_REL (default 130).
- R7: A code of at least TEMP_OFF (default 165), seen while plim_cut_o=1, shuts the output down (err_low_o=1, drive_en_o=0). This holds down to TEMP_REL. Below TEMP_REL the error is released and drive returns after the wake delay.
- R8: supply_ok_i low gives drive_en_o=0 with err_low_o=0 and clears latched faults. When supply returns, drive resumes after WAKE_CYC.
- R9: A dc_over_i bit held high for DC_CYC consecutive edges while driving latches a fault at the following edge. A shorter run leaves no fault. Counting is disabled, and the count cleared, while the output is not driving (mute included).
- R10: The priority is: sleep first, then undervoltage, then latched faults, then thermal shutdown, then mute, then normal drive.
- R11: With err_low_o wired back to sleep_ni, a one-cycle overcurrent leads to err_low_o=1 for one cycle, then release, then drive after WAKE_CYC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_ni | input | 1 | Low requests sleep |
| mute_ni | input | 1 | Low requests mute |
| supply_ok_i | input | 1 | Supply above threshold (hysteresis external) |
| ocp_i | input | NCH | Overcurrent flag per channel |
| temp_i | input | TW | Die temperature code in degrees C |
| dc_over_i | input | NCH | Output DC level above threshold per channel |
| drive_en_o | output | 1 | Output stage may drive |
| weak_low_o | output | 1 | Output stage held in weak pull-down |
| err_low_o | output | 1 | 1 pulls the open-drain error pin low, 0 releases it |
| plim_cut_o | output | 1 | Reduce power limit by 6 dB |

## Verification
The interesting collisions are between a trip and a request of different priority that land in the same cycle. The bench raises an overcurrent on the very cycle sleep_ni falls and expects no error and no surviving latch, since sleep wins. It raises one together with a falling mute_ni and expects the error, since a fault outranks mute. It also drops the supply while a thermal shutdown is active and expects the error pin released. Each case is judged from the output pins one edge later, and again after release: the wake time must be the normal one, and no fault may remain.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;
  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_UV    = 3'd1,
    ST_FAULT = 3'd2,
    ST_HOT   = 3'd3,
    ST_MUTE  = 3'd4,
    ST_WAKE  = 3'd5,
    ST_MRCV  = 3'd6,
    ST_RUN   = 3'd7
  } guard_st_e;
endpackage

// File: rtl/amp_guard_tmr.sv
module amp_guard_tmr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  a_r2_load_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(val_i)));
endmodule

// File: rtl/amp_guard_therm.sv
module amp_guard_therm #(
  parameter int TW       = 8,
  parameter int TEMP_LIM = 155,
  parameter int TEMP_OFF = 165,
  parameter int TEMP_REL = 130
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [TW-1:0] temp_i,
  output logic          limit_o,
  output logic          shut_o
);
  localparam logic [TW-1:0] LimC = TW'(TEMP_LIM);
  localparam logic [TW-1:0] OffC = TW'(TEMP_OFF);
  localparam logic [TW-1:0] RelC = TW'(TEMP_REL);

  logic lim_q, off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q <= 1'b0;
      off_q <= 1'b0;
    end else if (clr_i || temp_i < RelC) begin
      lim_q <= 1'b0;
      off_q <= 1'b0;
    end else begin
      if (temp_i >= LimC)          lim_q <= 1'b1;
      if (lim_q && temp_i >= OffC) off_q <= 1'b1;
    end
  end

  assign limit_o = lim_q;
  assign shut_o  = off_q;

  a_r7_shut_needs_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> lim_q);
  a_r6_release_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i < RelC) |=> !lim_q && !off_q);
endmodule

// File: rtl/amp_guard_dcdet.sv
module amp_guard_dcdet #(
  parameter int NCH    = 2,
  parameter int DC_CYC = 1000
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [NCH-1:0] dc_i,
  output logic           trip_o
);
  localparam int CW = $clog2(DC_CYC + 1);
  localparam logic [CW-1:0] Lim = CW'(DC_CYC);

  logic [NCH-1:0] hit;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (!en_i || !dc_i[c])  cnt_q <= '0;
      else if (cnt_q != Lim)       cnt_q <= cnt_q + 1'b1;
    end
    assign hit[c] = (cnt_q == Lim);

    a_r9_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (cnt_q == '0));
  end

  assign trip_o = |hit;
endmodule

// File: rtl/amp_guard.sv
module amp_guard
  import amp_guard_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int TW       = 8,
  parameter int WAKE_CYC = 4800,
  parameter int MUTE_CYC = 1200,
  parameter int DC_CYC   = 1000,
  parameter int TEMP_LIM = 155,
  parameter int TEMP_OFF = 165,
  parameter int TEMP_REL = 130
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sleep_ni,
  input  logic           mute_ni,
  input  logic           supply_ok_i,
  input  logic [NCH-1:0] ocp_i,
  input  logic [TW-1:0]  temp_i,
  input  logic [NCH-1:0] dc_over_i,
  output logic           drive_en_o,
  output logic           weak_low_o,
  output logic           err_low_o,
  output logic           plim_cut_o
);
  localparam int MaxCyc = (WAKE_CYC > MUTE_CYC) ? WAKE_CYC : MUTE_CYC;
  localparam int KW     = $clog2(MaxCyc + 1);
  localparam logic [KW-1:0] WakeLd = KW'(WAKE_CYC - 1);
  localparam logic [KW-1:0] MuteLd = KW'(MUTE_CYC - 1);

  guard_st_e state_q, state_d;
  logic need_wake_q, fault_q;
  logic dc_trip, trip, th_lim, th_shut;
  logic tmr_load, tmr_zero;
  logic [KW-1:0] tmr_val;
  logic alive;

  assign alive = sleep_ni && supply_ok_i;
  assign trip  = (|ocp_i) || dc_trip;

  amp_guard_therm #(
    .TW(TW), .TEMP_LIM(TEMP_LIM), .TEMP_OFF(TEMP_OFF), .TEMP_REL(TEMP_REL)
  ) u_therm (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(!sleep_ni), .temp_i(temp_i),
    .limit_o(th_lim), .shut_o(th_shut)
  );

  amp_guard_dcdet #(.NCH(NCH), .DC_CYC(DC_CYC)) u_dc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(state_q == ST_RUN && mute_ni),
    .dc_i(dc_over_i), .trip_o(dc_trip)
  );

  // fault latch: only sleep or supply loss clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     fault_q <= 1'b0;
    else if (!alive) fault_q <= 1'b0;
    else if (trip)   fault_q <= 1'b1;
  end

  always_comb begin
    state_d = state_q;
    if (!sleep_ni)               state_d = ST_SLEEP;
    else if (!supply_ok_i)       state_d = ST_UV;
    else if (fault_q || trip)    state_d = ST_FAULT;
    else if (th_shut)            state_d = ST_HOT;
    else if (!mute_ni)           state_d = ST_MUTE;
    else begin
      unique case (state_q)
        ST_SLEEP, ST_UV, ST_FAULT, ST_HOT: state_d = ST_WAKE;
        ST_MUTE:                   state_d = need_wake_q ? ST_WAKE : ST_MRCV;
        ST_WAKE, ST_MRCV:          state_d = tmr_zero ? ST_RUN : state_q;
        default:                   state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_SLEEP;
      need_wake_q <= 1'b1;
    end else begin
      state_q <= state_d;
      if (state_d inside {ST_SLEEP, ST_UV, ST_FAULT, ST_HOT}) need_wake_q <= 1'b1;
      else if (state_d == ST_RUN)                             need_wake_q <= 1'b0;
    end
  end

  assign tmr_load = (state_d != state_q) && (state_d == ST_WAKE || state_d == ST_MRCV);
  assign tmr_val  = (state_d == ST_WAKE) ? WakeLd : MuteLd;

  amp_guard_tmr #(.W(KW)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load), .val_i(tmr_val),
    .zero_o(tmr_zero)
  );

  assign drive_en_o = (state_q == ST_RUN);
  assign weak_low_o = (state_q != ST_RUN);
  assign err_low_o  = (state_q == ST_FAULT) || (state_q == ST_HOT);
  assign plim_cut_o = th_lim;

  a_r1_sleep_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_ni |=> !err_low_o && !drive_en_o && !plim_cut_o);
  a_r3_mute_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mute_ni |=> !drive_en_o);
  a_r4_trip_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alive && trip) |=> err_low_o && !drive_en_o);
  a_r5_latch_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alive && fault_q) |=> err_low_o);
  a_r8_uv_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_ni && !supply_ok_i) |=> !err_low_o && !drive_en_o);
  a_r2_drive_after_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_en_o) |-> $past(tmr_zero));
endmodule

// File: tb/amp_guard_test.sv
module amp_guard_test;
  localparam int ClkPer = 10;
  localparam int NCH = 2;
  localparam int WK = 20;
  localparam int MT = 10;
  localparam int DC = 15;

  logic clk = 0;
  logic rst_n = 0;
  logic sleep_drv = 1, mute_n = 1, sup_ok = 1, wire_back = 0;
  logic [NCH-1:0] ocp = '0, dcov = '0;
  logic [7:0] temp = 8'd25;
  logic sleep_n, drv, wl, err, plim;
  int checks = 0, errors = 0;

  assign sleep_n = sleep_drv && !(wire_back && err);

  always #(ClkPer/2) clk = ~clk;

  amp_guard #(.NCH(NCH), .TW(8), .WAKE_CYC(WK), .MUTE_CYC(MT), .DC_CYC(DC))
  uut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_ni(sleep_n), .mute_ni(mute_n),
    .supply_ok_i(sup_ok), .ocp_i(ocp), .temp_i(temp), .dc_over_i(dcov),
    .drive_en_o(drv), .weak_low_o(wl), .err_low_o(err), .plim_cut_o(plim)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // exp: {drive, weak, err, plim}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {drv, wl, err, plim};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s outs=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic chk_n(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges_to_drive(output int n);
    n = 0;
    do begin
      step(1);
      n++;
    end while (!drv && n < 500);
  endtask

  task automatic restart;
    int n;
    sleep_drv = 0; step(1);
    sleep_drv = 1; edges_to_drive(n);
  endtask

  task automatic t_boot;
    int n;
    chk("R1 reset state", 4'b0100);
    rst_n = 1;
    edges_to_drive(n);
    chk_n("R2 boot wake edges", n, WK + 1);
  endtask

  task automatic t_sleep;
    int n;
    sleep_drv = 0; step(1);
    chk("R1 sleep outputs", 4'b0100);
    step(4);
    sleep_drv = 1; edges_to_drive(n);
    chk_n("R2 wake edges", n, WK + 1);
  endtask

  task automatic t_mute;
    int n;
    mute_n = 0; step(1);
    chk("R3 mute outputs", 4'b0100);
    step(5);
    mute_n = 1; edges_to_drive(n);
    chk_n("R3 mute recovery edges", n, MT + 1);
  endtask

  task automatic t_ocp;
    int n;
    ocp = 2'b10; step(1); ocp = '0;
    chk("R4 ocp trip", 4'b0110);
    step(30);
    mute_n = 0; step(3); mute_n = 1; step(30);
    chk("R5 latch persists", 4'b0110);
    sleep_drv = 0; step(1);
    chk("R1 sleep clears latch", 4'b0100);
    sleep_drv = 1; edges_to_drive(n);
    chk_n("R1 wake after clear", n, WK + 1);
  endtask

  task automatic t_uv;
    int n;
    ocp = 2'b01; step(1); ocp = '0;
    chk("R4 ocp ch0", 4'b0110);
    sup_ok = 0; step(1);
    chk("R8 uv releases flag", 4'b0100);
    step(3);
    sup_ok = 1; edges_to_drive(n);
    chk_n("R8 uv recovery edges", n, WK + 1);
    chk("R8 latch gone after uv", 4'b1000);
  endtask

  task automatic t_therm;
    int n;
    temp = 8'd155; step(1);
    chk("R6 limit stage", 4'b1001);
    temp = 8'd140; step(5);
    chk("R6 hysteresis hold", 4'b1001);
    temp = 8'd129; step(1);
    chk("R6 release", 4'b1000);
    temp = 8'd170; step(1);
    chk("R7 first stage first", 4'b1001);
    step(2);
    chk("R7 shutdown", 4'b0111);
    temp = 8'd140; step(5);
    chk("R7 shutdown hold", 4'b0111);
    temp = 8'd120; edges_to_drive(n);
    chk_n("R7 shutdown recovery edges", n, WK + 2);
    chk("R7 resumed", 4'b1000);
  endtask

  task automatic t_dc;
    int n;
    dcov = 2'b01; step(DC - 1); dcov = '0; step(3);
    chk("R9 short dc no trip", 4'b1000);
    dcov = 2'b10; step(DC);
    chk("R9 still driving at limit", 4'b1000);
    step(1);
    chk("R9 dc trip", 4'b0110);
    dcov = '0; step(5);
    chk("R9 dc latched", 4'b0110);
    restart;
    mute_n = 0; dcov = 2'b01; step(2 * DC);
    chk("R9 muted no trip", 4'b0100);
    dcov = '0; mute_n = 1; edges_to_drive(n);
    chk_n("R9 mute exit clean", n, MT + 1);
    chk("R9 no fault after mute", 4'b1000);
  endtask

  task automatic t_prio;
    int n;
    ocp = 2'b01; sleep_drv = 0; step(1); ocp = '0;
    chk("R10 sleep beats ocp", 4'b0100);
    sleep_drv = 1; edges_to_drive(n);
    chk_n("R10 no latch left", n, WK + 1);
    ocp = 2'b01; mute_n = 0; step(1); ocp = '0;
    chk("R10 fault beats mute", 4'b0110);
    mute_n = 1; restart;
    temp = 8'd170; step(3);
    chk("R10 hot before uv", 4'b0111);
    sup_ok = 0; step(1);
    chk("R10 uv beats hot", 4'b0101);
    sup_ok = 1; temp = 8'd25; edges_to_drive(n);
    chk("R10 back to run", 4'b1000);
  endtask

  task automatic t_retry;
    int n;
    wire_back = 1;
    ocp = 2'b10; step(1); ocp = '0;
    chk("R11 flag raised", 4'b0110);
    step(1);
    chk("R11 self release", 4'b0100);
    edges_to_drive(n);
    chk_n("R11 retry wake edges", n, WK + 1);
    wire_back = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(3);
    t_boot;
    t_sleep;
    t_mute;
    t_ocp;
    t_uv;
    t_therm;
    t_dc;
    t_prio;
    t_retry;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule